// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Aggregator

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line passes through a two-flop synchronizer and is watched for rising edges. A detected edge latches a bit in a status word. An enable word masks that status word, and the masked result is the pending word. The single interrupt output to the processor is the OR of the pending word, gated by an output-enable bit. A helper output gives the index of the most significant pending line, together with a flag that is set when any line is pending.

Software reaches the block through a single-cycle register bus with word addresses. The enable word can be written whole, or changed one bit at a time through a set port and a clear port. Serviced lines are cleared by writing a mask to an acknowledge port. A two-bit control register brings the block up in two steps. Software first clears the status word while the block still ignores its request lines. It then switches the block to hardware operation, and finally enables the output.

Top module: `irq_hub`

## Requirements
- R1: After reset, the status, enable and control registers and all outputs are 0, and every address reads 0.
- R2: While the control hardware bit (offset 6, bit 1) is 1, a rising edge on `irq_src[i]` sets status bit i (offset 0) three clock edges after the line rises. A line held high does not set the bit again after it has been acknowledged.
- R3: Writing a mask to the acknowledge port (offset 3, write-only) clears every status bit whose mask bit is 1, several in one write.
- R4: Writing the enable register (offset 2) replaces the whole enable word, and writing 0 masks every line.
- R5: Writing the enable-set port (offset 4) ORs the data into the enable word, and writing the enable-clear port (offset 5) clears the enable bits whose data bits are 1. All other enable bits are unchanged. Both ports are write-only.
- R6: Reading the pending register (offset 1, read-only) returns status AND enable.
- R7: The control register (offset 6) holds output-enable in bit 0 and hardware-active in bit 1. While hardware-active is 0, the status register is written directly and the request lines are ignored. Once hardware-active is 1, status writes have no effect and only reset returns the bit to 0.
- R8: `irq_out` is 1 exactly when the pending word is nonzero and the output-enable bit is 1.
- R9: `top_valid` is 1 when the pending word is nonzero, and `top_idx` is the index of its most significant set bit (line 31 highest).
- R10: When an edge and an acknowledge of the same bit fall in the same cycle, the status bit ends up set.
- R11: Reads of addresses 3, 4, 5 and 7 return 0, and writes to address 7 change nothing.
- R12: Register writes and line edges take effect at the clock edge that samples them. `irq_out`, `top_idx` and `top_valid` show the new state right after that edge. `bus_rdata` shows, one edge later, the register at `bus_addr` as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 32 | Asynchronous request lines |
| irq_out | output | 1 | Processor interrupt |
| top_idx | output | 5 | Index of the highest pending line |
| top_valid | output | 1 | Some line is pending |

## Verification
On every cycle, the assertions check several properties: the hardware-active bit is sticky, no status bit rises without a matching detected edge once the block is active, inputs are ignored before that point, acknowledged bits clear unless an edge arrives with them, the enable-set port only adds bits, the output equals pending-any gated by output-enable, and the reported index is the top pending bit. Other behaviours need the bench's scenarios and its reference model. These are the exact three-edge latency from a line to its status bit, the two-step bring-up, the read-back timing and the masking of unmapped addresses. So is the case where a held level does not re-trigger after an acknowledge.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [2:0] {
    RG_STAT = 3'd0,
    RG_PEND = 3'd1,
    RG_ENA  = 3'd2,
    RG_ACK  = 3'd3,
    RG_ESET = 3'd4,
    RG_ECLR = 3'd5,
    RG_CTRL = 3'd6,
    RG_NONE = 3'd7
  } reg_sel_e;

  localparam int unsigned CTRL_OE_BIT = 0;
  localparam int unsigned CTRL_HW_BIT = 1;

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] raw,
  output logic [N_SRC-1:0] rise
);

  logic [N_SRC-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= raw;
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[k] <= '0;
      else     pipe[k] <= pipe[k-1];
    end
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    for (int unsigned i = 0; i < N_SRC; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any = |vec;
  end

endmodule

// File: rtl/irq_hub_state.sv
module irq_hub_state #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stat,
  input  logic             wr_ack,
  input  logic             wr_ena,
  input  logic             wr_eset,
  input  logic             wr_eclr,
  input  logic             wr_ctrl,
  input  logic [N_SRC-1:0] wdata,
  input  logic [N_SRC-1:0] rise,
  output logic [N_SRC-1:0] stat_q,
  output logic [N_SRC-1:0] ena_q,
  output logic             hw_q,
  output logic             oe_q,
  output logic [N_SRC-1:0] stat_d,
  output logic [N_SRC-1:0] ena_d,
  output logic             oe_d
);
  import irq_hub_pkg::*;

  logic [N_SRC-1:0] ack_mask;
  logic             hw_d;

  assign ack_mask = wr_ack ? wdata : '0;

  always_comb begin
    if (hw_q)         stat_d = (stat_q & ~ack_mask) | rise;
    else if (wr_stat) stat_d = wdata;
    else              stat_d = stat_q & ~ack_mask;
  end

  always_comb begin
    ena_d = ena_q;
    if (wr_ena)  ena_d = wdata;
    if (wr_eset) ena_d = ena_q | wdata;
    if (wr_eclr) ena_d = ena_q & ~wdata;
  end

  assign hw_d = hw_q | (wr_ctrl & wdata[CTRL_HW_BIT]);
  assign oe_d = wr_ctrl ? wdata[CTRL_OE_BIT] : oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ena_q  <= '0;
      hw_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      stat_q <= stat_d;
      ena_q  <= ena_d;
      hw_q   <= hw_d;
      oe_q   <= oe_d;
    end
  end

  a_r7_hw_sticky: assert property (@(posedge clk) disable iff (rst)
    hw_q |=> hw_q);

  a_r7_inputs_ignored: assert property (@(posedge clk) disable iff (rst)
    (!hw_q && !wr_stat) |=> ((stat_q & ~$past(stat_q)) == '0));

  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    hw_q |=> ((stat_q & ~$past(stat_q) & ~$past(rise)) == '0));

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> ((stat_q & $past(wdata) & ~$past(rise)) == '0));

  a_r10_edge_wins: assert property (@(posedge clk) disable iff (rst)
    hw_q |=> (($past(rise) & ~stat_q) == '0));

  a_r5_set_adds: assert property (@(posedge clk) disable iff (rst)
    (wr_eset && !wr_ena && !wr_eclr) |=> ((($past(ena_q) | $past(wdata)) & ~ena_q) == '0));

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  irq_src,
  output logic              irq_out,
  output logic [IDX_W-1:0]  top_idx,
  output logic              top_valid
);
  import irq_hub_pkg::*;

  logic             addr_ok;
  reg_sel_e         sel;
  logic             wr_stat, wr_ack, wr_ena, wr_eset, wr_eclr, wr_ctrl;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] stat_q, ena_q, stat_d, ena_d;
  logic             hw_q, oe_q, oe_d;
  logic [IDX_W-1:0] idx_d;
  logic             any_d;
  logic [N_SRC-1:0] rd_mux;

  assign addr_ok = (bus_addr >> 3) == '0;
  assign sel     = reg_sel_e'(bus_addr[2:0]);

  assign wr_stat = bus_we && addr_ok && (sel == RG_STAT);
  assign wr_ack  = bus_we && addr_ok && (sel == RG_ACK);
  assign wr_ena  = bus_we && addr_ok && (sel == RG_ENA);
  assign wr_eset = bus_we && addr_ok && (sel == RG_ESET);
  assign wr_eclr = bus_we && addr_ok && (sel == RG_ECLR);
  assign wr_ctrl = bus_we && addr_ok && (sel == RG_CTRL);

  irq_edge_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  (irq_src),
    .rise (rise)
  );

  irq_hub_state #(.N_SRC(N_SRC)) i_state (
    .clk     (clk),
    .rst     (rst),
    .wr_stat (wr_stat),
    .wr_ack  (wr_ack),
    .wr_ena  (wr_ena),
    .wr_eset (wr_eset),
    .wr_eclr (wr_eclr),
    .wr_ctrl (wr_ctrl),
    .wdata   (bus_wdata),
    .rise    (rise),
    .stat_q  (stat_q),
    .ena_q   (ena_q),
    .hw_q    (hw_q),
    .oe_q    (oe_q),
    .stat_d  (stat_d),
    .ena_d   (ena_d),
    .oe_d    (oe_d)
  );

  irq_prio_enc #(.N_SRC(N_SRC)) i_prio (
    .vec (stat_d & ena_d),
    .idx (idx_d),
    .any (any_d)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      case (sel)
        RG_STAT: rd_mux = stat_q;
        RG_PEND: rd_mux = stat_q & ena_q;
        RG_ENA:  rd_mux = ena_q;
        RG_CTRL: begin
          rd_mux[CTRL_OE_BIT] = oe_q;
          rd_mux[CTRL_HW_BIT] = hw_q;
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
      top_idx   <= '0;
      top_valid <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq_out   <= any_d & oe_d;
      top_idx   <= idx_d;
      top_valid <= any_d;
    end
  end

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_out == (top_valid && oe_q));

  a_r9_idx_is_top: assert property (@(posedge clk) disable iff (rst)
    top_valid |-> (((stat_q & ena_q) >> top_idx) == N_SRC'(1)));

  a_r9_valid_matches: assert property (@(posedge clk) disable iff (rst)
    top_valid == ((stat_q & ena_q) != '0));

endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
  localparam int N  = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic [N-1:0]  src = '0;
  logic          irq_out;
  logic [4:0]    top_idx;
  logic          top_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_hub i_irq_hub (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_src(src), .irq_out(irq_out),
    .top_idx(top_idx), .top_valid(top_valid)
  );

  // reference model
  logic [N-1:0] m_isr, m_ier, m_s1, m_s2, m_s3, m_rise, m_ack, m_pend;
  logic         m_hw, m_oe;
  logic [N-1:0] e_rd;
  logic         e_out, e_valid;
  logic [4:0]   e_idx;

  function automatic logic [N-1:0] model_read(logic [AW-1:0] a);
    case (a)
      3'd0: return m_isr;
      3'd1: return m_isr & m_ier;
      3'd2: return m_ier;
      3'd6: return {30'b0, m_hw, m_oe};
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_isr = '0; m_ier = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
      m_hw = 0; m_oe = 0; e_rd = '0; e_out = 0; e_valid = 0; e_idx = '0;
    end else begin
      e_rd   = model_read(addr);
      m_rise = m_s2 & ~m_s3;
      m_ack  = (we && addr == 3'd3) ? wdata : '0;
      if (m_hw) m_isr = (m_isr & ~m_ack) | m_rise;
      else if (we && addr == 3'd0) m_isr = wdata;
      else m_isr = m_isr & ~m_ack;
      if (we && addr == 3'd2) m_ier = wdata;
      if (we && addr == 3'd4) m_ier = m_ier | wdata;
      if (we && addr == 3'd5) m_ier = m_ier & ~wdata;
      if (we && addr == 3'd6) begin
        m_hw = m_hw | wdata[1];
        m_oe = wdata[0];
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = src;
      m_pend  = m_isr & m_ier;
      e_valid = (m_pend != 0);
      e_idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (m_pend[i]) begin e_idx = 5'(i); break; end
      end
      e_out = e_valid && m_oe;
    end
  end

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic string rd_tag(logic [AW-1:0] a);
    case (a)
      3'd0: return "R7 status read";
      3'd1: return "R6 pending read";
      3'd2: return "R4 enable read";
      3'd6: return "R7 control read";
      default: return "R11 write-only/unmapped read";
    endcase
  endfunction

  logic [AW-1:0] prev_addr = '0;
  bit started = 0;

  // every-cycle comparison against the model (R12 timing)
  always @(negedge clk) begin
    if (!rst && started) begin
      check("R8 irq_out", {31'b0, irq_out}, {31'b0, e_out});
      check("R9 top_valid", {31'b0, top_valid}, {31'b0, e_valid});
      if (e_valid) check("R9 top_idx", {27'b0, top_idx}, {27'b0, e_idx});
      check(rd_tag(prev_addr), rdata, e_rd);
    end
    prev_addr = addr;
    if (!rst) started = 1;
  end

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [N-1:0] v);
    @(negedge clk); we = 0; addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); src = src | m;
    repeat (4) @(negedge clk);
    src = src & ~m;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 irq_out", {31'b0, irq_out}, '0);
    check("R1 top_valid", {31'b0, top_valid}, '0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset read", v, '0);
    end
    // R7: software-writable status before hardware mode; inputs ignored
    wr(3'd0, 32'h0000_00A5);
    rd(3'd0, v); check("R7 status write pre-hw", v, 32'h0000_00A5);
    pulse(32'h0000_0100);
    rd(3'd0, v); check("R7 inputs ignored pre-hw", v, 32'h0000_00A5);
    wr(3'd0, 32'h0);
    // R7: two-step bring-up, sticky hardware bit
    wr(3'd6, 32'h2);
    wr(3'd6, 32'h0);
    rd(3'd6, v); check("R7 hw bit sticky", v, 32'h2);
    wr(3'd6, 32'h3);
    rd(3'd6, v); check("R7 control both bits", v, 32'h3);
    // R2, R6, R8, R9: edges latched
    wr(3'd2, 32'hFFFF_FFFF);
    pulse(32'h0002_0008);
    rd(3'd0, v); check("R2 edges latched", v, 32'h0002_0008);
    rd(3'd1, v); check("R6 pending", v, 32'h0002_0008);
    check("R9 idx 17", {27'b0, top_idx}, 32'd17);
    check("R8 irq asserted", {31'b0, irq_out}, 32'd1);
    // R3: multi-bit acknowledge
    wr(3'd3, 32'h0002_0008);
    check("R8 irq dropped after ack", {31'b0, irq_out}, 32'd0);
    rd(3'd0, v); check("R3 ack cleared", v, 32'h0);
    // R4, R5, R6, R9
    wr(3'd2, 32'h0000_0008);
    rd(3'd2, v); check("R4 enable replaced", v, 32'h0000_0008);
    pulse(32'h0010_0008);
    rd(3'd1, v); check("R6 pending masked", v, 32'h0000_0008);
    check("R9 idx 3", {27'b0, top_idx}, 32'd3);
    wr(3'd4, 32'h0010_0000);
    check("R9 idx 20 after set", {27'b0, top_idx}, 32'd20);
    rd(3'd2, v); check("R5 set one bit", v, 32'h0010_0008);
    wr(3'd5, 32'h0000_0008);
    rd(3'd2, v); check("R5 clear one bit", v, 32'h0010_0000);
    rd(3'd1, v); check("R6 pending after clear", v, 32'h0010_0000);
    // R8: output enable gating
    wr(3'd6, 32'h2);
    check("R8 gated off", {31'b0, irq_out}, 32'd0);
    check("R9 valid while gated", {31'b0, top_valid}, 32'd1);
    wr(3'd6, 32'h3);
    check("R8 gated on", {31'b0, irq_out}, 32'd1);
    // R7: status write ignored in hardware mode
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R7 status write ignored", v, 32'h0010_0008);
    wr(3'd3, 32'hFFFF_FFFF);
    // R2: held level does not retrigger
    @(negedge clk); src[5] = 1;
    repeat (5) @(negedge clk);
    wr(3'd3, 32'h0000_0020);
    repeat (6) @(negedge clk);
    rd(3'd0, v); check("R2 level no retrigger", v, 32'h0);
    @(negedge clk); src[5] = 0;
    repeat (4) @(negedge clk);
    // R10: edge and acknowledge in the same cycle
    @(negedge clk); src[9] = 1;
    @(negedge clk);
    @(negedge clk); we = 1; addr = 3'd3; wdata = 32'h0000_0200;
    @(negedge clk); we = 0;
    rd(3'd0, v); check("R10 edge wins over ack", v, 32'h0000_0200);
    @(negedge clk); src[9] = 0;
    // R11: unmapped address
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, v); check("R11 unmapped reads 0", v, 32'h0);
    rd(3'd2, v); check("R11 unmapped write ignored", v, 32'h0010_0000);
    rd(3'd3, v); check("R11 ack reads 0", v, 32'h0);
    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      we    = ($urandom % 3) == 0;
      addr  = 3'($urandom % 8);
      wdata = $urandom;
      src   = $urandom;
    end
    @(negedge clk); we = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule